// File: doc/BRIEF.md
# Coded Command Sequence Interface

This block sits on the bus side of a byte-wide flash model. It watches the chip-enable and write-enable strobes, which are active low, and treats their logical OR as a single write strobe. The address is captured when that strobe falls. The data byte is captured when it rises. Each completed bus write becomes one command cycle. The block then walks through a sequence machine that expects a two-cycle coded unlock before every setup command. Erase commands need the unlock a second time before their confirm byte. Well-formed sequences become one decoded request to the program/erase engine. Anything malformed puts the machine back at its first cycle and selects array reads.

The decoded request leaves through a valid/ready stream. A request holds `req_valid` and its fields steady until the engine raises `req_ready`. While a request waits without acceptance, the block drops any bus write that completes. The engine reports its own condition on three plain status inputs: busy, erasing and suspended. The block uses them only to decide which commands are legal. The output `autosel_mode` tells the read path whether reads should return identification data or array data.

Top module: `ccsi_top`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `req_valid` and `autosel_mode` are 0.
- R2: The address of a command cycle is the one present when the combined strobe (`ce_n | we_n`) falls. The data is the byte present when the strobe rises. Changes to the address bus between those two moments have no effect. The request appears two clock cycles after the rise is sampled.
- R3: The cycles (A0=0x555 low 11 address bits, 0xAA), (0x2AA, 0x55), then data 0x90 issue op 1 (auto-select) and set `autosel_mode` to 1. This requires the engine to be not busy.
- R4: Unlock, then 0xA0, then any byte at any address issues op 2 (program) carrying that address and that byte. This also applies when the byte is 0xF0. The sequence needs the engine to be not busy, and it may be suspended.
- R5: Unlock, then 0x80, then a second unlock, then a final byte. A final byte of 0x10 issues op 4 (chip erase). A final byte of 0x30 issues op 3 (block erase) with the address of that cycle. The sequence needs the engine to be neither busy nor suspended.
- R6: A wrong address or wrong byte on any cycle issues no request. It returns the machine to its first cycle and clears `autosel_mode`.
- R7: Data 0xF0 on any cycle other than the program data cycle issues op 0 (read array), clears `autosel_mode` and restarts the sequence.
- R8: A single write of 0xB0 issues op 5 (suspend) only while `eng_erasing` is 1 and `eng_suspended` is 0. Otherwise it counts as a wrong cycle.
- R9: A single write of 0x30 issues op 6 (resume) only while `eng_suspended` is 1. Otherwise it counts as a wrong cycle.
- R10: While `eng_busy` is 1, setup bytes 0x90, 0xA0 and 0x80 are rejected as wrong cycles.
- R11: While `req_valid` is 1 and `req_ready` is 0, the request fields stay stable, and every completed bus write is ignored.
- R12: Asserting `rst_n`, which models power-up and supply lockout, abandons any partial sequence and selects array reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset; also power-up and lockout |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr_i | input | AW (20) | Bus address |
| data_i | input | DW (8) | Bus data byte |
| eng_busy | input | 1 | Engine is running a program or erase |
| eng_erasing | input | 1 | Engine is running an erase |
| eng_suspended | input | 1 | An erase is suspended |
| req_valid | output | 1 | Decoded request available |
| req_ready | input | 1 | Engine accepts the request |
| req_op | output | 3 | Request code, 0 to 6 as listed in R3 to R9 |
| req_addr | output | AW (20) | Address of the issuing cycle |
| req_data | output | DW (8) | Data byte of the issuing cycle |
| autosel_mode | output | 1 | Reads return identification data |

## Verification
The assertions assume that the strobes change slowly relative to `clk`, so that each fall and each rise is sampled at least one cycle apart. They also assume that the engine status inputs stay steady around each command cycle. The stimulus meets both assumptions. It holds every strobe phase for whole clock periods. It changes the engine status only between instructions. It drains each request before the next write, except in the one directed case that checks the stall behaviour.

// File: rtl/ccsi_pkg.sv
package ccsi_pkg;

  typedef enum logic [2:0] {
    OP_RD_ARRAY   = 3'd0,
    OP_AUTOSEL    = 3'd1,
    OP_PROGRAM    = 3'd2,
    OP_BLK_ERASE  = 3'd3,
    OP_CHIP_ERASE = 3'd4,
    OP_SUSPEND    = 3'd5,
    OP_RESUME     = 3'd6
  } ccsi_op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_UNL1, S_UNL2, S_PROG, S_ERA3, S_ERA4, S_ERA5
  } ccsi_state_e;

  localparam logic [15:0] KEY_ADDR1 = 16'h0555;
  localparam logic [15:0] KEY_ADDR2 = 16'h02AA;
  localparam logic [7:0]  KEY_DATA1 = 8'hAA;
  localparam logic [7:0]  KEY_DATA2 = 8'h55;
  localparam logic [7:0]  CMD_AUTOSEL = 8'h90;
  localparam logic [7:0]  CMD_PROGRAM = 8'hA0;
  localparam logic [7:0]  CMD_ERASE   = 8'h80;
  localparam logic [7:0]  CMD_CHIP    = 8'h10;
  localparam logic [7:0]  CMD_BLOCK   = 8'h30;
  localparam logic [7:0]  CMD_SUSPEND = 8'hB0;
  localparam logic [7:0]  CMD_RESUME  = 8'h30;
  localparam logic [7:0]  CMD_RESET   = 8'hF0;

endpackage

// File: rtl/ccsi_strobe.sv
module ccsi_strobe #(
  parameter int AW = 20,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          ev_o,
  output logic [AW-1:0] ev_addr_o,
  output logic [DW-1:0] ev_data_o
);
  logic          strobe;
  logic          strobe_q;
  logic          fall;
  logic          rise;
  logic [AW-1:0] addr_lat;

  assign strobe = ce_n | we_n;
  assign fall   = strobe_q & ~strobe;
  assign rise   = ~strobe_q & strobe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q  <= 1'b1;
      addr_lat  <= '0;
      ev_o      <= 1'b0;
      ev_addr_o <= '0;
      ev_data_o <= '0;
    end else begin
      strobe_q <= strobe;
      ev_o     <= rise;
      if (fall) addr_lat <= addr_i;
      if (rise) begin
        ev_addr_o <= addr_lat;
        ev_data_o <= data_i;
      end
    end
  end
endmodule

// File: rtl/ccsi_seq.sv
module ccsi_seq
  import ccsi_pkg::*;
#(
  parameter int AW  = 20,
  parameter int DW  = 8,
  parameter int KAW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev,
  input  logic          hold,
  input  logic [AW-1:0] ev_addr,
  input  logic [DW-1:0] ev_data,
  input  logic          eng_busy,
  input  logic          eng_erasing,
  input  logic          eng_suspended,
  output logic          issue,
  output ccsi_op_e      issue_op,
  output logic          autosel_q
);
  localparam logic [KAW-1:0] KA1 = KAW'(KEY_ADDR1);
  localparam logic [KAW-1:0] KA2 = KAW'(KEY_ADDR2);

  ccsi_state_e state_q, state_d;
  logic        autosel_d;
  logic        take;
  logic        key1, key2;
  logic        fault;
  logic [7:0]  cmd;

  assign take = ev & ~hold;
  assign cmd  = 8'(ev_data);
  assign key1 = (ev_addr[KAW-1:0] == KA1) && (cmd == KEY_DATA1);
  assign key2 = (ev_addr[KAW-1:0] == KA2) && (cmd == KEY_DATA2);

  always_comb begin
    state_d   = state_q;
    autosel_d = autosel_q;
    issue     = 1'b0;
    issue_op  = OP_RD_ARRAY;
    fault     = 1'b0;
    if (take) begin
      if (state_q != S_PROG && cmd == CMD_RESET) begin
        state_d   = S_IDLE;
        autosel_d = 1'b0;
        issue     = 1'b1;
        issue_op  = OP_RD_ARRAY;
      end else begin
        unique case (state_q)
          S_IDLE: begin
            if (cmd == CMD_SUSPEND && eng_erasing && !eng_suspended) begin
              issue    = 1'b1;
              issue_op = OP_SUSPEND;
            end else if (cmd == CMD_RESUME && eng_suspended) begin
              issue    = 1'b1;
              issue_op = OP_RESUME;
            end else if (key1) begin
              state_d = S_UNL1;
            end else begin
              fault = 1'b1;
            end
          end
          S_UNL1: if (key2) state_d = S_UNL2; else fault = 1'b1;
          S_UNL2: begin
            if (cmd == CMD_AUTOSEL && !eng_busy) begin
              state_d   = S_IDLE;
              autosel_d = 1'b1;
              issue     = 1'b1;
              issue_op  = OP_AUTOSEL;
            end else if (cmd == CMD_PROGRAM && !eng_busy) begin
              state_d = S_PROG;
            end else if (cmd == CMD_ERASE && !eng_busy && !eng_suspended) begin
              state_d = S_ERA3;
            end else begin
              fault = 1'b1;
            end
          end
          S_PROG: begin
            state_d  = S_IDLE;
            issue    = 1'b1;
            issue_op = OP_PROGRAM;
          end
          S_ERA3: if (key1) state_d = S_ERA4; else fault = 1'b1;
          S_ERA4: if (key2) state_d = S_ERA5; else fault = 1'b1;
          S_ERA5: begin
            state_d = S_IDLE;
            if (cmd == CMD_CHIP) begin
              issue    = 1'b1;
              issue_op = OP_CHIP_ERASE;
            end else if (cmd == CMD_BLOCK) begin
              issue    = 1'b1;
              issue_op = OP_BLK_ERASE;
            end else begin
              fault = 1'b1;
            end
          end
          default: fault = 1'b1;
        endcase
        if (fault) begin
          state_d   = S_IDLE;
          autosel_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      autosel_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      autosel_q <= autosel_d;
    end
  end
endmodule

// File: rtl/ccsi_reqq.sv
module ccsi_reqq
  import ccsi_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  ccsi_op_e      op_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          ready,
  output logic          valid,
  output logic [2:0]    op_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o,
  output logic          hold_o
);
  assign hold_o = valid & ~ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      op_o   <= 3'd0;
      addr_o <= '0;
      data_o <= '0;
    end else if (load) begin
      valid  <= 1'b1;
      op_o   <= op_i;
      addr_o <= addr_i;
      data_o <= data_i;
    end else if (ready) begin
      valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/ccsi_top.sv
module ccsi_top
  import ccsi_pkg::*;
#(
  parameter int AW  = 20,
  parameter int DW  = 8,
  parameter int KAW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          eng_busy,
  input  logic          eng_erasing,
  input  logic          eng_suspended,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [2:0]    req_op,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_data,
  output logic          autosel_mode
);
  logic          ev;
  logic [AW-1:0] ev_addr;
  logic [DW-1:0] ev_data;
  logic          issue;
  ccsi_op_e      issue_op;
  logic          hold;

  ccsi_strobe #(.AW(AW), .DW(DW)) u_strobe (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n),
    .addr_i(addr_i), .data_i(data_i),
    .ev_o(ev), .ev_addr_o(ev_addr), .ev_data_o(ev_data)
  );

  ccsi_seq #(.AW(AW), .DW(DW), .KAW(KAW)) u_seq (
    .clk(clk), .rst_n(rst_n), .ev(ev), .hold(hold),
    .ev_addr(ev_addr), .ev_data(ev_data),
    .eng_busy(eng_busy), .eng_erasing(eng_erasing),
    .eng_suspended(eng_suspended),
    .issue(issue), .issue_op(issue_op), .autosel_q(autosel_mode)
  );

  ccsi_reqq #(.AW(AW), .DW(DW)) u_reqq (
    .clk(clk), .rst_n(rst_n), .load(issue), .op_i(issue_op),
    .addr_i(ev_addr), .data_i(ev_data), .ready(req_ready),
    .valid(req_valid), .op_o(req_op), .addr_o(req_addr),
    .data_o(req_data), .hold_o(hold)
  );
endmodule

// File: rtl/ccsi_checker.sv
module ccsi_checker #(
  parameter int AW = 20,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [2:0]    req_op,
  input logic [AW-1:0] req_addr,
  input logic [DW-1:0] req_data,
  input logic          autosel_mode,
  input logic          eng_busy,
  input logic          eng_erasing,
  input logic          eng_suspended
);
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (!req_valid && !autosel_mode));

  p_hold_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=>
      (req_valid && $stable(req_op) && $stable(req_addr) && $stable(req_data)));

  p_autosel_issue_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(autosel_mode) |-> (req_valid && req_op == 3'd1));

  p_suspend_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(req_valid) && req_op == 3'd5) |-> $past(eng_erasing && !eng_suspended));

  p_resume_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(req_valid) && req_op == 3'd6) |-> $past(eng_suspended));

  p_erase_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(req_valid) && (req_op == 3'd3 || req_op == 3'd4))
      |-> $past(!eng_busy && !eng_suspended));

  p_op_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_op <= 3'd6));
endmodule

bind ccsi_top ccsi_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
  .autosel_mode(autosel_mode), .eng_busy(eng_busy),
  .eng_erasing(eng_erasing), .eng_suspended(eng_suspended)
);

// File: tb/tb_ccsi_top.sv
`timescale 1ns/1ps
module tb_ccsi_top;
  localparam int AW = 20;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic          eng_busy = 1'b0, eng_erasing = 1'b0, eng_suspended = 1'b0;
  logic          req_valid, req_ready = 1'b0;
  logic [2:0]    req_op;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_data;
  logic          autosel_mode;

  int checks = 0, fails = 0;
  bit done = 0;
  int ms = 0;
  bit m_auto = 0;

  always #4 clk = ~clk;

  ccsi_top dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr_i(addr),
    .data_i(data), .eng_busy(eng_busy), .eng_erasing(eng_erasing),
    .eng_suspended(eng_suspended), .req_valid(req_valid),
    .req_ready(req_ready), .req_op(req_op), .req_addr(req_addr),
    .req_data(req_data), .autosel_mode(autosel_mode)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [AW-1:0] ka(input logic [10:0] low);
    return {AW'($urandom) & ~AW'(11'h7FF)} | AW'(low);
  endfunction

  // Bench reference: states 0 idle,1 unl1,2 unl2,3 prog,4 era3,5 era4,6 era5
  task automatic model(input logic [AW-1:0] a, input logic [7:0] d,
                       output bit v, output logic [2:0] op);
    bit k1, k2, bad;
    k1 = (a[10:0] == 11'h555) && (d == 8'hAA);
    k2 = (a[10:0] == 11'h2AA) && (d == 8'h55);
    v = 0; op = 0; bad = 0;
    if (ms != 3 && d == 8'hF0) begin ms = 0; m_auto = 0; v = 1; op = 0; end
    else begin
      case (ms)
        0: if (d == 8'hB0 && eng_erasing && !eng_suspended) begin v = 1; op = 5; end
           else if (d == 8'h30 && eng_suspended) begin v = 1; op = 6; end
           else if (k1) ms = 1; else bad = 1;
        1: if (k2) ms = 2; else bad = 1;
        2: if (d == 8'h90 && !eng_busy) begin ms = 0; m_auto = 1; v = 1; op = 1; end
           else if (d == 8'hA0 && !eng_busy) ms = 3;
           else if (d == 8'h80 && !eng_busy && !eng_suspended) ms = 4;
           else bad = 1;
        3: begin ms = 0; v = 1; op = 2; end
        4: if (k1) ms = 5; else bad = 1;
        5: if (k2) ms = 6; else bad = 1;
        default: begin
          ms = 0;
          if (d == 8'h10) begin v = 1; op = 4; end
          else if (d == 8'h30) begin v = 1; op = 3; end
          else bad = 1;
        end
      endcase
      if (bad) begin ms = 0; m_auto = 0; end
    end
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); ce_n = 0; we_n = 0; addr = a; data = 8'($urandom);
    @(negedge clk); addr = AW'($urandom);
    @(negedge clk); data = d; if ($urandom % 2) we_n = 1; else ce_n = 1;
    @(negedge clk); ce_n = 1; we_n = 1; data = 8'($urandom);
    repeat (2) @(negedge clk);
  endtask

  task automatic consume();
    if (req_valid) begin
      @(negedge clk); req_ready = 1;
      @(negedge clk); req_ready = 0;
    end
  endtask

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd0: return "R7"; 3'd1: return "R3"; 3'd2: return "R4";
      3'd3, 3'd4: return "R5"; 3'd5: return "R8"; default: return "R9";
    endcase
  endfunction

  // write, compare against the model, then drain
  task automatic step(input logic [AW-1:0] a, input logic [7:0] d);
    bit v; logic [2:0] op;
    model(a, d, v, op);
    bus_wr(a, d);
    check(v ? tag_of(op) : "R6 no-request", 32'(req_valid), 32'(v));
    if (v && req_valid) begin
      check(tag_of(op), 32'(req_op), 32'(op));
      if (op == 3'd2 || op == 3'd3) check("R2 addr", 32'(req_addr), 32'(a));
      if (op == 3'd2) check("R4 data", 32'(req_data), 32'(d));
    end
    check("R6 mode", 32'(autosel_mode), 32'(m_auto));
    consume();
  endtask

  task automatic unlock();
    step(ka(11'h555), 8'hAA);
    step(ka(11'h2AA), 8'h55);
  endtask

  task automatic set_eng(input int k);
    eng_busy = (k == 1 || k == 2); eng_erasing = (k == 2); eng_suspended = (k == 3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] qa[6];
    logic [7:0]    qd[6];
    int n;
    repeat (3) @(negedge clk);
    check("R1 valid", 32'(req_valid), 0);
    check("R1 mode", 32'(autosel_mode), 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 valid after", 32'(req_valid), 0);

    // directed
    unlock(); step(ka(11'h123), 8'h90);                 // R3
    check("R3 mode", 32'(autosel_mode), 1);
    unlock(); step(ka(11'h555), 8'hA0); step(20'hABCDE, 8'hF0);  // R4 F0 as data
    unlock(); step(ka(11'h555), 8'h80); unlock(); step(20'h34000, 8'h30); // R5 block
    unlock(); step(ka(11'h555), 8'h80); unlock(); step(ka(11'h555), 8'h10); // R5 chip
    unlock(); step(ka(11'h556), 8'h90);                  // R6 correct data, fine: setup any addr
    step(ka(11'h554), 8'hAA); step(ka(11'h2AA), 8'h55);  // R6 bad address
    step(ka(11'h555), 8'hA0);
    unlock(); step(ka(11'h555), 8'h80); step(ka(11'h555), 8'hF0); // R7 mid-erase
    set_eng(2); step(ka(0), 8'hB0);                     // R8 legal
    set_eng(0); step(ka(0), 8'hB0);                     // R8 illegal
    set_eng(3); step(ka(0), 8'h30);                     // R9 legal
    unlock(); step(ka(0), 8'hA0); step(20'h00042, 8'h5A); // R4 during suspend
    unlock(); step(ka(0), 8'h80);                       // R10 erase while suspended
    set_eng(0); step(ka(0), 8'h30);                     // R9 illegal
    set_eng(1); unlock(); step(ka(0), 8'hA0);           // R10 busy
    set_eng(0);

    // R11: stall, extra writes are dropped
    bus_wr(ka(11'h555), 8'hF0);
    check("R11 pending", 32'(req_valid), 1);
    bus_wr(ka(11'h555), 8'hAA); bus_wr(ka(11'h2AA), 8'h55); bus_wr(ka(0), 8'h90);
    check("R11 still", 32'(req_valid), 1);
    check("R11 op", 32'(req_op), 0);
    check("R11 mode", 32'(autosel_mode), 0);
    consume();
    check("R11 drained", 32'(req_valid), 0);
    ms = 0; m_auto = 0;

    // R12: reset abandons a partial sequence
    unlock(); step(ka(0), 8'h90); unlock();
    @(negedge clk); rst_n = 0; @(negedge clk);
    check("R12 mode", 32'(autosel_mode), 0);
    rst_n = 1; ms = 0; m_auto = 0;
    step(ka(0), 8'hA0); step(ka(0), 8'h77);
    check("R12 none", 32'(req_valid), 0);

    // constrained random
    void'($urandom(32'h5EED));
    for (int i = 0; i < 300; i++) begin
      set_eng($urandom % 4);
      qa[0] = ka(11'h555); qd[0] = 8'hAA; qa[1] = ka(11'h2AA); qd[1] = 8'h55;
      qa[3] = ka(11'h555); qd[3] = 8'hAA; qa[4] = ka(11'h2AA); qd[4] = 8'h55;
      qa[2] = AW'($urandom); qa[5] = AW'($urandom);
      n = 3;
      case ($urandom % 8)
        0: begin qa[0] = AW'($urandom); qd[0] = 8'hF0; n = 1; end
        1: qd[2] = 8'h90;
        2: begin qd[2] = 8'hA0; qa[3] = AW'($urandom); qd[3] = 8'($urandom); n = 4; end
        3: begin qd[2] = 8'h80; qd[5] = 8'h10; n = 6; end
        4: begin qd[2] = 8'h80; qd[5] = 8'h30; n = 6; end
        5: begin qd[0] = 8'hB0; n = 1; end
        6: begin qd[0] = 8'h30; n = 1; end
        default: begin qa[0] = AW'($urandom); qd[0] = 8'($urandom); n = 1; end
      endcase
      if ($urandom % 5 == 0) begin
        int j = $urandom % n;
        if ($urandom % 2) qd[j] = qd[j] ^ 8'(1 << ($urandom % 8));
        else qa[j] = qa[j] ^ AW'(1 << ($urandom % 11));
      end
      for (int j = 0; j < n; j++) step(qa[j], qd[j]);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule